// File: doc/BRIEF.md
# DMA Linked-List Descriptor Fetcher

This block reloads the working register file of one DMA channel from a chain of descriptors held in memory. The channel's link register carries six update-enable flags and a 16-bit word offset. When the data-movement engine reports that the current transfer has finished, the block examines that word. If every flag and the offset are zero, the chain has ended: the block raises a transfer-complete pulse and reloads nothing. Otherwise it reads the next descriptor one 32-bit word at a time through a simple memory read port and overwrites only the registers whose flags are set.

A descriptor has a variable length. Each enabled register takes the next word address, starting at the offset, and disabled registers take no memory slot. The flags and offset are captured when the fetch starts, so a link word that arrives partway through a fetch only steers the following descriptor. A memory error response stops the fetch, leaves the registers not yet written as they were, and sets a sticky error flag. Software writes any register through a small write port. A write to block register 1 also records the value that the block restores at reload time when the descriptor does not carry that register.

The sequencer has five named states:
- `ST_IDLE` waits for `xfer_done`.
- `ST_REQ` holds a read request until it is accepted.
- `ST_WAIT` waits for the single outstanding response.
- `ST_FIN` pulses `reload_done` for one cycle.
- `ST_CMPL` pulses `xfer_cmplt` for one cycle.

Its transitions are:
- IDLE→CMPL when the chain ends.
- IDLE→FIN when the flags are zero but the offset is not.
- IDLE→REQ when at least one flag is set.
- REQ→WAIT on a handshake.
- WAIT→REQ while enabled words remain.
- WAIT→FIN after the last word.
- WAIT→IDLE on an error response.
- FIN→IDLE and CMPL→IDLE unconditionally.

Top module: `lli_fetch_top`

## Requirements
- R1: After reset all six registers read 0 and `reload_done`, `xfer_cmplt`, `mem_req_valid`, `link_err` and `busy` are 0.
- R2: On `xfer_done` with a link register whose six flags and offset are all 0, `xfer_cmplt` pulses for one cycle, no memory read is issued, and no register changes (block register 1 keeps its working value).
- R3: Register select codes are 0 TR1, 1 TR2, 2 BR1, 3 SAR, 4 DAR, 5 LLR. Link register bit 16+k enables reload of the register with code k. Enabled registers are read in ascending code order from consecutive word addresses offset, offset+4, … (16-bit wrap). Disabled ones take no slot.
- R4: A register whose flag is set is overwritten with the word read for it. A register whose flag is clear keeps its value.
- R5: If BR1's flag is clear and the chain continues, BR1 is set back to the value last written to it by software or memory, discarding decrements.
- R6: The link register stores only bits [21:16] and [15:2]. All other bits, including the two offset LSBs, read 0.
- R7: Flags and offset are captured at fetch start. A software write of the link register during a fetch changes neither the addresses nor the set of registers of that fetch.
- R8: `mem_req_valid` with its address is held until `mem_req_ready`, and no new request is made until the response of the previous one arrives.
- R9: At the end of a continuing fetch, `reload_done` pulses for exactly one cycle. `xfer_done` while `busy` is ignored.
- R10: A response with `mem_rsp_err` aborts the fetch without `reload_done`. Registers not yet written, including BR1, keep their values. `link_err` stays 1 until software writes the link register.
- R11: Each `blk_dec` cycle lowers BR1's working value by 1, stopping at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_we | input | 1 | Software register write strobe |
| sw_sel | input | 3 | Software write target code |
| sw_wdata | input | 32 | Software write data |
| blk_dec | input | 1 | Decrement BR1 working value |
| xfer_done | input | 1 | Current data transfer finished |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 16 | Read word address (byte offset) |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_data | input | 32 | Read response data |
| mem_rsp_err | input | 1 | Read response error |
| reg_tr1 | output | 32 | Transfer register 1 |
| reg_tr2 | output | 32 | Transfer register 2 |
| reg_br1 | output | 32 | Block register 1 working value |
| reg_sar | output | 32 | Source address register |
| reg_dar | output | 32 | Destination address register |
| reg_llr | output | 32 | Link register |
| reload_done | output | 1 | One-cycle reload finished pulse |
| xfer_cmplt | output | 1 | One-cycle chain complete pulse |
| link_err | output | 1 | Sticky fetch error flag |
| busy | output | 1 | Sequencer not idle |

## Verification
The hardest condition to reach from the ports is a software write of the link register that lands while a fetch is already under way. It has to arrive after the first read has been accepted and before the last response. The bench slows the memory by accepting requests only every other cycle and adding response latency. It waits until the first request has been logged, then writes a new link word and pulses `xfer_done` again. Finally it checks the address log, the final link value and the count of `reload_done` pulses. The error abort is reached by making the model fail one chosen address in the middle of a descriptor.

// File: rtl/lli_pkg.sv
package lli_pkg;
    localparam int NREG     = 6;
    localparam int SEL_W    = 3;
    localparam int IDX_TR1  = 0;
    localparam int IDX_TR2  = 1;
    localparam int IDX_BR1  = 2;
    localparam int IDX_SAR  = 3;
    localparam int IDX_DAR  = 4;
    localparam int IDX_LLR  = 5;
    localparam int FLAG_LSB = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_FIN,
        ST_CMPL
    } seq_state_e;
endpackage

// File: rtl/lli_slot_pick.sv
module lli_slot_pick #(
    parameter int N = 6,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  pend,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) idx = IW'(i);
        end
        any = |pend;
    end
endmodule

// File: rtl/lli_regfile.sv
module lli_regfile
    import lli_pkg::*;
#(
    parameter int DW    = 32,
    parameter int OFS_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sw_we,
    input  logic [SEL_W-1:0]          sw_sel,
    input  logic [DW-1:0]             sw_wdata,
    input  logic                      ld_we,
    input  logic [SEL_W-1:0]          ld_sel,
    input  logic [DW-1:0]             ld_data,
    input  logic                      restore_br1,
    input  logic                      blk_dec,
    output logic [NREG-1:0][DW-1:0]   rf_q
);
    localparam logic [DW-1:0] FLAG_MASK = DW'({NREG{1'b1}}) << FLAG_LSB;
    localparam logic [DW-1:0] PTR_MASK  = DW'((64'd1 << OFS_W) - 64'd4);
    localparam logic [DW-1:0] LLR_MASK  = FLAG_MASK | PTR_MASK;

    logic [DW-1:0] br1_prog;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            br1_prog <= '0;
        end else if (ld_we && ld_sel == SEL_W'(IDX_BR1)) begin
            br1_prog <= ld_data;
        end else if (sw_we && sw_sel == SEL_W'(IDX_BR1)) begin
            br1_prog <= sw_wdata;
        end
    end

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        localparam logic [DW-1:0] MSK = (k == IDX_LLR) ? LLR_MASK : {DW{1'b1}};
        logic [DW-1:0] r;
        logic hit_ld, hit_sw;
        assign hit_ld = ld_we && ld_sel == SEL_W'(k);
        assign hit_sw = sw_we && sw_sel == SEL_W'(k);
        assign rf_q[k] = r;

        if (k == IDX_BR1) begin : g_br1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)            r <= '0;
                else if (hit_ld)       r <= ld_data;
                else if (hit_sw)       r <= sw_wdata;
                else if (restore_br1)  r <= br1_prog;
                else if (blk_dec && r != '0) r <= r - 1'b1;
            end
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       r <= '0;
                else if (hit_ld)  r <= ld_data & MSK;
                else if (hit_sw)  r <= sw_wdata & MSK;
            end
        end
    end

    // R6
    llr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_q[IDX_LLR] & ~LLR_MASK) == '0);

    // R5
    br1_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_br1 |=> rf_q[IDX_BR1] == $past(br1_prog));

    // R11
    br1_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_dec && !restore_br1 && !ld_we && !sw_we && rf_q[IDX_BR1] == '0)
        |=> rf_q[IDX_BR1] == '0);
endmodule

// File: rtl/lli_seq.sv
module lli_seq
    import lli_pkg::*;
#(
    parameter int DW    = 32,
    parameter int OFS_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               xfer_done,
    input  logic [DW-1:0]      llr_q,
    input  logic               sw_we,
    input  logic [SEL_W-1:0]   sw_sel,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [OFS_W-1:0]   mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [DW-1:0]      mem_rsp_data,
    input  logic               mem_rsp_err,
    output logic               ld_we,
    output logic [SEL_W-1:0]   ld_sel,
    output logic [DW-1:0]      ld_data,
    output logic               restore_br1,
    output logic               reload_done,
    output logic               xfer_cmplt,
    output logic               link_err,
    output logic               busy
);
    localparam int WW  = OFS_W - 2;
    localparam int CW  = $clog2(NREG + 1);
    localparam int IW  = $clog2(NREG);

    seq_state_e        state, state_nx;
    logic [NREG-1:0]   pend;
    logic [WW-1:0]     word_base;
    logic [CW-1:0]     wcnt;
    logic              br1_keep;
    logic [IW-1:0]     cur;
    logic              cur_any;
    logic [NREG-1:0]   live_flags;
    logic [WW-1:0]     live_ptr;
    logic [NREG-1:0]   pend_after;
    logic              rsp_ok;
    logic              br1_flag_now;

    assign live_flags = llr_q[FLAG_LSB +: NREG];
    assign live_ptr   = llr_q[OFS_W-1:2];
    assign rsp_ok     = mem_rsp_valid && !mem_rsp_err;

    lli_slot_pick #(.N(NREG)) u_pick (
        .pend (pend),
        .idx  (cur),
        .any  (cur_any)
    );

    always_comb begin
        pend_after = pend;
        pend_after[cur] = 1'b0;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (xfer_done) begin
                    if (live_flags == '0 && live_ptr == '0) state_nx = ST_CMPL;
                    else if (live_flags == '0)              state_nx = ST_FIN;
                    else                                    state_nx = ST_REQ;
                end
            end
            ST_REQ:  if (mem_req_ready) state_nx = ST_WAIT;
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err)           state_nx = ST_IDLE;
                    else if (pend_after == '0) state_nx = ST_FIN;
                    else                       state_nx = ST_REQ;
                end
            end
            ST_FIN:  state_nx = ST_IDLE;
            ST_CMPL: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // fetch context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend      <= '0;
            word_base <= '0;
            wcnt      <= '0;
            br1_keep  <= 1'b0;
        end else if (state == ST_IDLE && xfer_done) begin
            pend      <= live_flags;
            word_base <= live_ptr;
            wcnt      <= '0;
            br1_keep  <= live_flags[IDX_BR1];
        end else if (state == ST_WAIT && rsp_ok) begin
            pend      <= pend_after;
            wcnt      <= wcnt + 1'b1;
        end
    end

    // sticky error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                         link_err <= 1'b0;
        else if (state == ST_WAIT && mem_rsp_valid && mem_rsp_err) link_err <= 1'b1;
        else if (sw_we && sw_sel == SEL_W'(IDX_LLR))        link_err <= 1'b0;
    end

    assign br1_flag_now = (state == ST_IDLE) ? live_flags[IDX_BR1] : br1_keep;

    // outputs
    always_comb begin
        mem_req_valid = (state == ST_REQ);
        mem_req_addr  = {word_base + WW'(wcnt), 2'b00};
        ld_we         = (state == ST_WAIT) && rsp_ok && cur_any;
        ld_sel        = SEL_W'(cur);
        ld_data       = mem_rsp_data;
        restore_br1   = (state_nx == ST_FIN) && (state != ST_FIN) && !br1_flag_now;
        reload_done   = (state == ST_FIN);
        xfer_cmplt    = (state == ST_CMPL);
        busy          = (state != ST_IDLE);
    end

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R8
    one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    // R3
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[1:0] == 2'b00);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_done |=> !reload_done);

    // R2
    cmplt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_cmplt |=> (!xfer_cmplt && !mem_req_valid));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_err && !(sw_we && sw_sel == SEL_W'(IDX_LLR))) |=> link_err);
endmodule

// File: rtl/lli_fetch_top.sv
module lli_fetch_top
    import lli_pkg::*;
#(
    parameter int DW    = 32,
    parameter int OFS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [2:0]        sw_sel,
    input  logic [DW-1:0]     sw_wdata,
    input  logic              blk_dec,
    input  logic              xfer_done,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [OFS_W-1:0]  mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DW-1:0]     mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic [DW-1:0]     reg_tr1,
    output logic [DW-1:0]     reg_tr2,
    output logic [DW-1:0]     reg_br1,
    output logic [DW-1:0]     reg_sar,
    output logic [DW-1:0]     reg_dar,
    output logic [DW-1:0]     reg_llr,
    output logic              reload_done,
    output logic              xfer_cmplt,
    output logic              link_err,
    output logic              busy
);
    logic [NREG-1:0][DW-1:0] rf_q;
    logic                    ld_we;
    logic [SEL_W-1:0]        ld_sel;
    logic [DW-1:0]           ld_data;
    logic                    restore_br1;

    lli_regfile #(.DW(DW), .OFS_W(OFS_W)) u_rf (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_we       (sw_we),
        .sw_sel      (sw_sel),
        .sw_wdata    (sw_wdata),
        .ld_we       (ld_we),
        .ld_sel      (ld_sel),
        .ld_data     (ld_data),
        .restore_br1 (restore_br1),
        .blk_dec     (blk_dec),
        .rf_q        (rf_q)
    );

    lli_seq #(.DW(DW), .OFS_W(OFS_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .xfer_done     (xfer_done),
        .llr_q         (rf_q[IDX_LLR]),
        .sw_we         (sw_we),
        .sw_sel        (sw_sel),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_rsp_err   (mem_rsp_err),
        .ld_we         (ld_we),
        .ld_sel        (ld_sel),
        .ld_data       (ld_data),
        .restore_br1   (restore_br1),
        .reload_done   (reload_done),
        .xfer_cmplt    (xfer_cmplt),
        .link_err      (link_err),
        .busy          (busy)
    );

    assign reg_tr1 = rf_q[IDX_TR1];
    assign reg_tr2 = rf_q[IDX_TR2];
    assign reg_br1 = rf_q[IDX_BR1];
    assign reg_sar = rf_q[IDX_SAR];
    assign reg_dar = rf_q[IDX_DAR];
    assign reg_llr = rf_q[IDX_LLR];

    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reload_done && xfer_cmplt));
endmodule

// File: tb/lli_fetch_top_bench.sv
module lli_fetch_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_we = 1'b0;
    logic [2:0]  sw_sel = '0;
    logic [31:0] sw_wdata = '0;
    logic        blk_dec = 1'b0;
    logic        xfer_done = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [15:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;
    logic [31:0] reg_tr1, reg_tr2, reg_br1, reg_sar, reg_dar, reg_llr;
    logic        reload_done, xfer_cmplt, link_err, busy;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    lli_fetch_top u_lli_fetch_top (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
        .blk_dec(blk_dec), .xfer_done(xfer_done),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .reg_tr1(reg_tr1), .reg_tr2(reg_tr2), .reg_br1(reg_br1), .reg_sar(reg_sar),
        .reg_dar(reg_dar), .reg_llr(reg_llr),
        .reload_done(reload_done), .xfer_cmplt(xfer_cmplt), .link_err(link_err), .busy(busy)
    );

    localparam logic [31:0] LLR_MASK = 32'h003F_FFFC;

    function automatic logic [31:0] mword(input logic [15:0] a);
        return {~a, a};
    endfunction

    // memory model
    logic        slow = 1'b0;
    logic        clr_log = 1'b0;
    logic        err_on = 1'b0;
    logic [15:0] err_addr = '0;
    logic [15:0] log_a [8];
    int          nreq = 0;
    int          nrsp = 0;
    int          nrd  = 0;
    int          hold_bad = 0;
    int          dly = 0;
    logic [15:0] lat_addr = '0;
    logic        prev_wait = 1'b0;
    logic [15:0] prev_addr = '0;

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        mem_rsp_err   <= 1'b0;
        mem_req_ready <= slow ? ~mem_req_ready : 1'b1;
        prev_wait     <= mem_req_valid && !mem_req_ready;
        prev_addr     <= mem_req_addr;
        if (prev_wait && (!mem_req_valid || mem_req_addr != prev_addr)) hold_bad <= hold_bad + 1;
        if (reload_done) nrd <= nrd + 1;
        if (clr_log) begin
            nreq <= 0; nrsp <= 0; nrd <= 0; dly <= 0;
        end else if (mem_req_valid && mem_req_ready) begin
            lat_addr <= mem_req_addr;
            dly <= slow ? 3 : 1;
            if (nreq < 8) log_a[nreq] <= mem_req_addr;
            nreq <= nreq + 1;
        end else if (dly != 0) begin
            dly <= dly - 1;
            if (dly == 1) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mword(lat_addr);
                mem_rsp_err   <= err_on && (lat_addr == err_addr);
                nrsp <= nrsp + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic sw_write(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_sel = sel; sw_wdata = d;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic clear_log();
        @(negedge clk); clr_log = 1'b1;
        @(negedge clk); clr_log = 1'b0;
    endtask

    // returns 1 for reload_done, 2 for xfer_cmplt, 0 for none
    task automatic wait_end(output int kind);
        kind = 0;
        for (int i = 0; i < 400; i++) begin
            if (reload_done) begin kind = 1; return; end
            if (xfer_cmplt)  begin kind = 2; return; end
            @(negedge clk);
        end
    endtask

    function automatic logic [31:0] init_val(input int k);
        return 32'h1000_0000 * (k + 1) + 32'h0000_0A5A;
    endfunction

    task automatic program_all(input logic [31:0] llr);
        for (int k = 0; k < 5; k++) sw_write(3'(k), (k == 2) ? 32'h40 : init_val(k));
        @(negedge clk); blk_dec = 1'b1;
        @(negedge clk); @(negedge clk); blk_dec = 1'b0;
        sw_write(3'd5, llr);
    endtask

    function automatic logic [31:0] get_reg(input int k);
        case (k)
            0: return reg_tr1;
            1: return reg_tr2;
            2: return reg_br1;
            3: return reg_sar;
            4: return reg_dar;
            default: return reg_llr;
        endcase
    endfunction

    // vectors: {expected outcome kind (1 reload, 2 complete), link word}
    localparam int NV = 6;
    localparam logic [33:0] VEC [NV] = '{
        {2'd2, 32'h0000_0000},
        {2'd1, 32'h003F_0100},
        {2'd1, 32'h0005_0203},
        {2'd1, 32'h0000_0040},
        {2'd1, 32'h0030_FFFC},
        {2'd1, 32'h001A_0080}
    };

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 tr1", reg_tr1, 0); chk("R1 br1", reg_br1, 0); chk("R1 llr", reg_llr, 0);
        chk("R1 pulses", {28'd0, reload_done, xfer_cmplt, mem_req_valid, link_err}, 0);
        chk("R1 busy", {31'd0, busy}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R6 link register masking
        sw_write(3'd5, 32'hFFFF_FFFF);
        chk("R6 llr mask", reg_llr, 32'h003F_FFFC);

        // table walk: R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            logic [31:0] w;
            logic [5:0]  fl;
            logic [15:0] p;
            logic [31:0] exp_r [6];
            logic [15:0] exp_a [6];
            int n;
            int kind;
            w  = VEC[v][31:0];
            fl = w[21:16];
            p  = w[15:0] & 16'hFFFC;
            program_all(w);
            clear_log();
            pulse_done();
            wait_end(kind);
            n = 0;
            for (int k = 0; k < 6; k++) begin
                if (fl[k]) begin
                    exp_a[n] = p + 16'(4 * n);
                    exp_r[k] = mword(exp_a[n]) & ((k == 5) ? LLR_MASK : 32'hFFFF_FFFF);
                    n++;
                end else if (k == 2) begin
                    exp_r[k] = (VEC[v][33:32] == 2'd2) ? 32'h3E : 32'h40;
                end else begin
                    exp_r[k] = (k == 5) ? (w & LLR_MASK) : init_val(k);
                end
            end
            chk((VEC[v][33:32] == 2'd2) ? "R2 outcome" : "R9 outcome", kind, 32'(VEC[v][33:32]));
            for (int k = 0; k < 6; k++)
                chk((k == 2) ? "R5 br1" : "R4 reg", get_reg(k), exp_r[k]);
            @(negedge clk);
            chk("R3 read count", nreq, n);
            for (int j = 0; j < n; j++) chk("R3 addr", {16'd0, log_a[j]}, {16'd0, exp_a[j]});
        end
        chk("R8 hold", hold_bad, 0);

        // R7 / R9 / R8 : link write and xfer_done during a slow fetch
        slow = 1'b1;
        program_all(32'h0007_0300);
        clear_log();
        pulse_done();
        for (int i = 0; i < 100 && nreq < 1; i++) @(negedge clk);
        sw_write(3'd5, 32'h0000_0500);
        pulse_done();
        begin
            int kind;
            wait_end(kind);
            chk("R7 outcome", kind, 1);
        end
        repeat (20) @(negedge clk);
        chk("R7 count", nreq, 3);
        chk("R7 addr0", {16'd0, log_a[0]}, 32'h300);
        chk("R7 addr2", {16'd0, log_a[2]}, 32'h308);
        chk("R7 llr", reg_llr, 32'h0000_0500);
        chk("R7 tr2", reg_tr2, mword(16'h304));
        chk("R9 single pulse", nrd, 1);
        chk("R9 idle", {31'd0, busy}, 0);
        chk("R8 hold slow", hold_bad, 0);
        chk("R8 one outstanding", nreq - nrsp, 0);
        slow = 1'b0;

        // R10 error abort on second read
        program_all(32'h0039_0400);
        err_on = 1'b1; err_addr = 16'h404;
        clear_log();
        pulse_done();
        for (int i = 0; i < 100 && busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R10 tr1 loaded", reg_tr1, mword(16'h400));
        chk("R10 sar kept", reg_sar, init_val(3));
        chk("R10 dar kept", reg_dar, init_val(4));
        chk("R10 llr kept", reg_llr, 32'h0039_0400);
        chk("R10 br1 kept", reg_br1, 32'h3E);
        chk("R10 err", {31'd0, link_err}, 1);
        chk("R10 no done", nrd, 0);
        err_on = 1'b0;
        repeat (5) @(negedge clk);
        chk("R10 sticky", {31'd0, link_err}, 1);
        sw_write(3'd5, 32'h0);
        chk("R10 cleared", {31'd0, link_err}, 0);

        // R11 decrement floor
        sw_write(3'd2, 32'h1);
        @(negedge clk); blk_dec = 1'b1;
        repeat (3) @(negedge clk); blk_dec = 1'b0;
        chk("R11 floor", reg_br1, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule